// File: doc/BRIEF.md
# Protection Level Transition Controller

This block keeps the flash read-protection level as an 8-bit option code and handles every request to reprogram that code. Two byte values have a meaning of their own: 0xAA selects the open level and 0x55 the partial level. Every other byte selects the locked level, which is the most restrictive one. Moving to a stricter level takes effect at once. A move down to the open level is held back until a wipe has finished. The wipe clears flash main memory, the backup registers and all SRAMs, one after the other.

Each wipe target has an erase engine with a start/done handshake. The controller gives each engine a start pulse, waits for that engine's done, and then moves on to the next target. While the wipe runs, the controller shows busy and ignores any new program strobe. A request that has no legal path, locked to partial, is refused and raises a one-cycle error pulse.

Top module: `prot_level_ctrl`

## Requirements
- R1: The level output encodes the stored code as 0 = open (code 0xAA), 1 = partial (code 0x55) and 2 = locked (any other code). After reset the stored code is RESET_CODE, which defaults to 0xFF, so the level is locked.
- R2: A program strobe with a locked code while the level is open or partial sets the level to locked at the next clock edge. No erase_start pulse is issued and busy stays low.
- R3: A program strobe with 0xAA while the level is partial or locked raises busy at the next edge. In the same cycle erase_start[0] pulses.
- R4: The wipe order is flash main memory (bit 0), then backup registers (bit 1), then SRAM (bit 2). Each erase_start bit is a single-cycle pulse, and at most one bit is high at a time. erase_start[i+1] pulses in the cycle after erase_done[i] is sampled high.
- R5: During a wipe the level keeps its old value. The edge that samples the last erase_done both sets the level to open and clears busy.
- R6: A program strobe received while busy is high has no effect. The level, the wipe and illegal_err are all unchanged.
- R7: A program strobe whose code decodes to the current level has no effect. This includes 0xAA while the level is already open: no erase, no busy, no level change.
- R8: A program strobe with 0x55 while the level is locked is refused. The level stays locked and illegal_err is high for exactly the one cycle after the strobe.
- R9: A program strobe with 0x55 while the level is open sets the level to partial at the next edge, without any erase.
- R10: During a wipe, an erase_done bit of any target other than the one being waited on is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_valid | input | 1 | Program strobe for the option code |
| prog_value | input | 8 | Option code to be programmed |
| erase_done | input | NUM_TGT (3) | Done pulses from the erase engines (bit 0 flash, 1 backup, 2 SRAM) |
| level | output | 2 | Decoded protection level (0 open, 1 partial, 2 locked) |
| erase_start | output | NUM_TGT (3) | Start pulses to the erase engines |
| busy | output | 1 | A wipe is in progress |
| illegal_err | output | 1 | One-cycle pulse after a refused transition |

## Verification
The code decoder and transition classifier are tried with magic and non-magic bytes from each starting level:
- 0x3C and 0xFF while locked show that a same-level rewrite does nothing.
- 0x00 and 0x12 from partial and open show the direct upgrade.
- 0x55 from open shows the allowed move to partial.
- 0x55 from locked shows the refused move.

The wipe is run from both the locked and the partial level:
- In the run from locked, stray done pulses for other targets and program strobes arrive while busy. These show whether the sequencer waits on the right engine and whether the level register stays closed until the last done.
- In the run from partial, the engines answer back to back, which exposes any extra cycle or skipped step in the order.

// File: rtl/prot_lvl_pkg.sv
package prot_lvl_pkg;

  typedef enum logic [1:0] {
    LVL_OPEN    = 2'd0,
    LVL_PARTIAL = 2'd1,
    LVL_LOCKED  = 2'd2
  } lvl_e;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_COMMIT = 2'd1,
    ACT_WIPE   = 2'd2,
    ACT_REJECT = 2'd3
  } act_e;

  localparam logic [7:0] CODE_OPEN    = 8'hAA;
  localparam logic [7:0] CODE_PARTIAL = 8'h55;

  // Byte to level: two magic codes, everything else is the strictest level.
  function automatic lvl_e decode_level(input logic [7:0] code);
    lvl_e l;
    if (code == CODE_OPEN)         l = LVL_OPEN;
    else if (code == CODE_PARTIAL) l = LVL_PARTIAL;
    else                           l = LVL_LOCKED;
    return l;
  endfunction

  // What a requested move from cur to nxt must do.
  function automatic act_e classify(input lvl_e cur, input lvl_e nxt);
    act_e a;
    if (nxt == cur)              a = ACT_NONE;
    else if (nxt == LVL_OPEN)    a = ACT_WIPE;
    else if (nxt == LVL_LOCKED)  a = ACT_COMMIT;
    else if (cur == LVL_OPEN)    a = ACT_COMMIT;
    else                         a = ACT_REJECT;
    return a;
  endfunction

endpackage

// File: rtl/prot_lvl_decide.sv
module prot_lvl_decide
  import prot_lvl_pkg::*;
(
  input  logic [7:0] cur_code,
  input  logic [7:0] new_code,
  output lvl_e       cur_lvl,
  output lvl_e       new_lvl,
  output act_e       action
);

  always_comb begin
    cur_lvl = decode_level(cur_code);
    new_lvl = decode_level(new_code);
    action  = classify(cur_lvl, new_lvl);
  end

endmodule

// File: rtl/prot_wipe_seq.sv
module prot_wipe_seq #(
  parameter int NUM_TGT = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               launch,
  input  logic [NUM_TGT-1:0] done_in,
  output logic [NUM_TGT-1:0] start_out,
  output logic               active,
  output logic               finish
);

  localparam int IDX_W = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_TGT - 1);

  logic [IDX_W-1:0] idx_q;
  logic             pulse_q;
  logic             cur_done;

  assign cur_done = active && done_in[idx_q];
  assign finish   = cur_done && (idx_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      idx_q   <= '0;
      pulse_q <= 1'b0;
    end else if (!active) begin
      pulse_q <= launch;
      if (launch) begin
        active <= 1'b1;
        idx_q  <= '0;
      end
    end else begin
      pulse_q <= 1'b0;
      if (cur_done) begin
        if (idx_q == LAST_IDX) begin
          active <= 1'b0;
        end else begin
          idx_q   <= idx_q + 1'b1;
          pulse_q <= 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_TGT; g++) begin : g_start
    assign start_out[g] = pulse_q && (idx_q == IDX_W'(g));
  end

endmodule

// File: rtl/prot_lvl_store.sv
module prot_lvl_store #(
  parameter logic [7:0] RESET_CODE = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       commit_en,
  input  logic [7:0] commit_code,
  output logic [7:0] code_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)         code_q <= RESET_CODE;
    else if (commit_en) code_q <= commit_code;
  end

endmodule

// File: rtl/prot_level_ctrl.sv
module prot_level_ctrl
  import prot_lvl_pkg::*;
#(
  parameter int         NUM_TGT    = 3,
  parameter logic [7:0] RESET_CODE = 8'hFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               prog_valid,
  input  logic [7:0]         prog_value,
  input  logic [NUM_TGT-1:0] erase_done,
  output logic [1:0]         level,
  output logic [NUM_TGT-1:0] erase_start,
  output logic               busy,
  output logic               illegal_err
);

  logic [7:0] code_q;
  lvl_e       cur_lvl;
  lvl_e       new_lvl;
  act_e       action;
  logic       take_strobe;
  logic       direct_commit;
  logic       launch;
  logic       reject;
  logic       wipe_finish;
  logic       commit_en;
  logic [7:0] commit_code;

  prot_lvl_decide u_decide (
    .cur_code (code_q),
    .new_code (prog_value),
    .cur_lvl  (cur_lvl),
    .new_lvl  (new_lvl),
    .action   (action)
  );

  assign take_strobe   = prog_valid && !busy;
  assign direct_commit = take_strobe && (action == ACT_COMMIT);
  assign launch        = take_strobe && (action == ACT_WIPE);
  assign reject        = take_strobe && (action == ACT_REJECT);

  prot_wipe_seq #(.NUM_TGT(NUM_TGT)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .done_in   (erase_done),
    .start_out (erase_start),
    .active    (busy),
    .finish    (wipe_finish)
  );

  assign commit_en   = direct_commit || wipe_finish;
  assign commit_code = wipe_finish ? CODE_OPEN : prog_value;

  prot_lvl_store #(.RESET_CODE(RESET_CODE)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit_en   (commit_en),
    .commit_code (commit_code),
    .code_q      (code_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) illegal_err <= 1'b0;
    else        illegal_err <= reject;
  end

  assign level = cur_lvl;

endmodule

// File: rtl/prot_level_ctrl_chk.sv
module prot_level_ctrl_chk #(
  parameter int NUM_TGT = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               prog_valid,
  input logic [NUM_TGT-1:0] erase_done,
  input logic [1:0]         level,
  input logic [NUM_TGT-1:0] erase_start,
  input logic               busy,
  input logic               illegal_err,
  input logic               launch,
  input logic               wipe_finish
);

  assert_start_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(erase_start));

  assert_start_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|erase_start) |=> !(|(erase_start & $past(erase_start))));

  assert_start_needs_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|erase_start) |-> busy);

  for (genvar g = 1; g < NUM_TGT; g++) begin : g_order
    assert_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
      erase_start[g] |-> $past(erase_done[g-1]) && $past(busy));
  end

  assert_first_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy && erase_start[0]);

  assert_commit_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wipe_finish |=> !busy && (level == 2'd0));

  assert_level_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(level));

  assert_reject_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_err |-> (level == 2'd2) && $stable(level));

  assert_reject_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_err |=> !illegal_err);

endmodule

bind prot_level_ctrl prot_level_ctrl_chk #(.NUM_TGT(NUM_TGT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .prog_valid  (prog_valid),
  .erase_done  (erase_done),
  .level       (level),
  .erase_start (erase_start),
  .busy        (busy),
  .illegal_err (illegal_err),
  .launch      (launch),
  .wipe_finish (wipe_finish)
);

// File: tb/test_prot_level_ctrl.sv
module test_prot_level_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       prog_valid = 1'b0;
  logic [7:0] prog_value = 8'h00;
  logic [2:0] erase_done = 3'b000;
  logic [1:0] level;
  logic [2:0] erase_start;
  logic       busy;
  logic       illegal_err;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  prot_level_ctrl i_prot_level_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .prog_valid  (prog_valid),
    .prog_value  (prog_value),
    .erase_done  (erase_done),
    .level       (level),
    .erase_start (erase_start),
    .busy        (busy),
    .illegal_err (illegal_err)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      n_checks = n_checks + 1;
      n_fail   = n_fail + 1;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Strobe one code; returns at the negedge after the sampling edge.
  task automatic prog(input logic [7:0] v);
    @(negedge clk);
    prog_valid = 1'b1;
    prog_value = v;
    @(negedge clk);
    prog_valid = 1'b0;
  endtask

  task automatic done_pulse(input int i);
    @(negedge clk);
    erase_done = 3'b001 << i;
    @(negedge clk);
    erase_done = 3'b000;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset level", level, 2);
    check("R1 reset busy", busy, 0);
    check("R1 reset start", erase_start, 0);
    check("R1 reset err", illegal_err, 0);
  endtask

  task automatic t_reject_partial;
    prog(8'h55);
    check("R8 err pulse", illegal_err, 1);
    check("R8 level kept", level, 2);
    check("R8 no busy", busy, 0);
    @(negedge clk);
    check("R8 err one cycle", illegal_err, 0);
  endtask

  task automatic t_same_level(input logic [7:0] v, input int lv);
    prog(v);
    check("R7 level same", level, lv);
    check("R7 no busy", busy, 0);
    check("R7 no start", erase_start, 0);
    check("R7 no err", illegal_err, 0);
  endtask

  task automatic t_wipe_slow;
    prog(8'hAA);
    check("R3 busy", busy, 1);
    check("R3 start flash", erase_start, 3'b001);
    check("R5 level held", level, 2);
    @(negedge clk);
    check("R4 pulse single", erase_start, 0);
    done_pulse(2);
    check("R10 stray done ignored start", erase_start, 0);
    check("R10 stray done busy", busy, 1);
    prog(8'h55);
    check("R6 no err while busy", illegal_err, 0);
    check("R6 level while busy", level, 2);
    done_pulse(0);
    check("R4 start backup", erase_start, 3'b010);
    check("R5 level held 2", level, 2);
    prog(8'h00);
    check("R6 busy kept", busy, 1);
    check("R6 level kept", level, 2);
    done_pulse(1);
    check("R4 start sram", erase_start, 3'b100);
    @(negedge clk);
    check("R5 level held 3", level, 2);
    done_pulse(2);
    check("R5 level open", level, 0);
    check("R5 busy cleared", busy, 0);
    check("R4 no start after", erase_start, 0);
  endtask

  task automatic t_direct(input logic [7:0] v, input int lv, input string req);
    prog(v);
    check(req, level, lv);
    check({req, " no busy"}, busy, 0);
    check({req, " no start"}, erase_start, 0);
  endtask

  // Engines answer immediately: each done in the cycle after its start.
  task automatic t_wipe_fast;
    @(negedge clk);
    prog_valid = 1'b1;
    prog_value = 8'hAA;
    @(negedge clk);
    prog_valid = 1'b0;
    check("R3 start from partial", erase_start, 3'b001);
    erase_done = 3'b001;
    @(negedge clk);
    check("R4 fast backup", erase_start, 3'b010);
    erase_done = 3'b010;
    @(negedge clk);
    check("R4 fast sram", erase_start, 3'b100);
    check("R5 fast held", level, 1);
    erase_done = 3'b100;
    @(negedge clk);
    erase_done = 3'b000;
    check("R5 fast open", level, 0);
    check("R5 fast idle", busy, 0);
  endtask

  initial begin
    t_reset();
    t_reject_partial();
    t_same_level(8'h3C, 2);
    t_same_level(8'hFF, 2);
    t_wipe_slow();
    t_same_level(8'hAA, 0);
    t_direct(8'h55, 1, "R9 open to partial");
    t_direct(8'h00, 2, "R2 partial to locked");
    t_reject_partial();
    // Back to partial through open, then wipe from partial.
    prog(8'hAA);
    done_pulse(0);
    done_pulse(1);
    done_pulse(2);
    check("R5 open again", level, 0);
    t_direct(8'h55, 1, "R9 open to partial again");
    t_wipe_fast();
    t_direct(8'h12, 2, "R2 open to locked");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule